// File: doc/BRIEF.md
# Serial EEPROM Burst Word Reader

This block is a master for the three-wire-plus-select serial EEPROM bus (Microwire style). It fetches a run of consecutive 16-bit words. The host sets a first word address and a word count, then pulses `start`. The controller runs one complete read frame per word. Each frame raises the select, sends the start bit and read opcode, shifts out the address MSB first, and then clocks 17 bits back from the device. The first returned bit is a placeholder zero and is dropped. The other sixteen bits make up the word.

Each word appears on `rd_data` for one cycle, qualified by `rd_valid` and tagged with its position in the run on `rd_idx`. A one-cycle `done` pulse closes the run. The serial clock is made from the system clock. The low phase lasts `DIV` system cycles and the high phase lasts `3*DIV`. At 125 MHz with `DIV=32`, this gives 256 ns low and 768 ns high, which meets the 250 ns and 750 ns minimums. `WIDE_ADDR` chooses a 6-bit address (0) or an 8-bit address (1).

Top module: `mw_burst_rd`

## Requirements
- R1: While reset is held and right after it, `ee_cs`, `ee_sck`, `ee_mosi`, `busy`, `rd_valid` and `done` are all 0.
- R2: Every frame begins with `ee_cs` rising while `ee_sck` is low. It then runs one serial clock with `ee_mosi`=0, followed by the bits 1, 1, 0 (start bit plus read opcode 10). After that come the address bits, MSB first: 6 bits when `WIDE_ADDR`=0, 8 bits when it is 1.
- R3: After the address, a frame runs exactly 17 serial clocks. The device drives each returned bit after a rising edge. The controller samples `ee_miso` in the last system cycle of each high phase. The first sample is discarded, and the remaining 16 form `rd_data`, MSB first.
- R4: Frame k of a run (k from 0) addresses `start_addr+k` modulo 2^address-width. When `ee_cs` drops at the end of frame k, `rd_valid` pulses for one cycle with `rd_idx`=k.
- R5: After every frame, `ee_cs` stays low for exactly one serial clock before the next frame starts. After the last frame, that single clock is followed by a one-cycle `done` pulse with `busy` low.
- R6: The serial clock low phase lasts `DIV` system cycles and the high phase lasts `3*DIV`.
- R7: `ee_mosi` changes only in cycles where `ee_sck` is low.
- R8: A `start` pulse while `busy` is high has no effect on the run in progress: no extra words, addresses or frames.
- R9: A `start` with `word_count`=0 gives `done` in the next cycle, with no select or clock activity.
- R10: `busy` goes high in the cycle after an accepted `start` with a nonzero count, stays high while `ee_cs` is high, and falls together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run |
| start_addr | input | AW | First word address (AW = 6 or 8) |
| word_count | input | AW+1 | Number of words to read |
| busy | output | 1 | Run in progress |
| rd_valid | output | 1 | Word strobe |
| rd_data | output | 16 | Word read from the device |
| rd_idx | output | AW+1 | Position of the word within the run |
| done | output | 1 | One-cycle end-of-run pulse |
| ee_cs | output | 1 | Device select |
| ee_sck | output | 1 | Serial clock |
| ee_mosi | output | 1 | Serial data to the device |
| ee_miso | input | 1 | Serial data from the device |

## Verification
A bad bit or phase counter shows up within one frame, as a wrong number of leading zeros, opcode bits, address bits or read clocks. The behavioural device model in the bench checks each of these at the serial edge where it occurs. An address or index register off by one shows up as a word mismatch or a wrong `rd_idx` at the first `rd_valid` of the run. A divider fault shows up at the first serial clock edge as a wrong phase length. A wrong end-of-run decision shows up either as a missing `done` or as an extra frame that no expected address accounts for.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int WORD_W   = 16;
  localparam int RX_BITS  = WORD_W + 1;
  localparam logic [2:0] RD_CMD = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_GAP
  } mw_state_t;
endpackage

// File: rtl/mw_sck_gen.sv
module mw_sck_gen #(
  parameter int LO_T = 32,
  parameter int HI_T = 96,
  localparam int TW = $clog2(HI_T + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck,
  output logic slot_end
);
  logic [TW-1:0] cnt;
  logic          hi;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (!hi) begin
      if (cnt == TW'(LO_T - 1)) begin
        hi  <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt == TW'(HI_T - 1)) begin
        hi  <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign sck      = hi;
  assign slot_end = run && hi && (cnt == TW'(HI_T - 1));

  // independent high-phase length counter for checking
  logic [TW:0] hlen;
  always_ff @(posedge clk) begin
    if (rst) hlen <= '0;
    else if (hi) hlen <= hlen + 1'b1;
    else hlen <= '0;
  end

  p_high_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(hi) |-> (hlen == (TW+1)'(HI_T)));
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)     word <= '0;
    else if (en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/mw_burst_rd.sv
module mw_burst_rd
  import mw_pkg::*;
#(
  parameter bit WIDE_ADDR = 1'b0,
  parameter int DIV = 32,
  localparam int AW = WIDE_ADDR ? 8 : 6,
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic [CW-1:0]     word_count,
  output logic              busy,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [CW-1:0]     rd_idx,
  output logic              done,
  output logic              ee_cs,
  output logic              ee_sck,
  output logic              ee_mosi,
  input  logic              ee_miso
);
  localparam int LO_T = DIV;
  localparam int HI_T = 3 * DIV;
  localparam int BW   = $clog2(RX_BITS);

  mw_state_t     st;
  logic [BW-1:0] bitc;
  logic [AW-1:0] cur_addr, addr_sh;
  logic [2:0]    cmd_sh;
  logic [CW-1:0] idx, last_idx;
  logic          slot_end, run, rx_en;

  assign run   = (st != ST_IDLE);
  assign rx_en = (st == ST_DATA) && slot_end;

  mw_sck_gen #(.LO_T(LO_T), .HI_T(HI_T)) u_sck (
    .clk(clk), .rst(rst), .run(run), .sck(ee_sck), .slot_end(slot_end)
  );

  mw_rx_shift #(.W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .en(rx_en), .din(ee_miso), .word(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bitc     <= '0;
      cur_addr <= '0;
      addr_sh  <= '0;
      cmd_sh   <= '0;
      idx      <= '0;
      last_idx <= '0;
      busy     <= 1'b0;
      rd_valid <= 1'b0;
      rd_idx   <= '0;
      done     <= 1'b0;
      ee_cs    <= 1'b0;
      ee_mosi  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (st == ST_IDLE) begin
        if (start) begin
          if (word_count == '0) begin
            done <= 1'b1;
          end else begin
            st       <= ST_SEL;
            busy     <= 1'b1;
            ee_cs    <= 1'b1;
            ee_mosi  <= 1'b0;
            cur_addr <= start_addr;
            addr_sh  <= start_addr;
            cmd_sh   <= RD_CMD;
            idx      <= '0;
            last_idx <= word_count - 1'b1;
          end
        end
      end else if (slot_end) begin
        case (st)
          ST_SEL: begin
            st      <= ST_CMD;
            bitc    <= '0;
            ee_mosi <= cmd_sh[2];
            cmd_sh  <= {cmd_sh[1:0], 1'b0};
          end
          ST_CMD: begin
            if (bitc == BW'(2)) begin
              st      <= ST_ADDR;
              bitc    <= '0;
              ee_mosi <= addr_sh[AW-1];
              addr_sh <= {addr_sh[AW-2:0], 1'b0};
            end else begin
              bitc    <= bitc + 1'b1;
              ee_mosi <= cmd_sh[2];
              cmd_sh  <= {cmd_sh[1:0], 1'b0};
            end
          end
          ST_ADDR: begin
            if (bitc == BW'(AW - 1)) begin
              st      <= ST_DATA;
              bitc    <= '0;
              ee_mosi <= 1'b0;
            end else begin
              bitc    <= bitc + 1'b1;
              ee_mosi <= addr_sh[AW-1];
              addr_sh <= {addr_sh[AW-2:0], 1'b0};
            end
          end
          ST_DATA: begin
            if (bitc == BW'(RX_BITS - 1)) begin
              st       <= ST_GAP;
              bitc     <= '0;
              ee_cs    <= 1'b0;
              rd_valid <= 1'b1;
              rd_idx   <= idx;
            end else begin
              bitc <= bitc + 1'b1;
            end
          end
          ST_GAP: begin
            if (idx == last_idx) begin
              st   <= ST_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              st       <= ST_SEL;
              ee_cs    <= 1'b1;
              cur_addr <= cur_addr + 1'b1;
              addr_sh  <= cur_addr + 1'b1;
              cmd_sh   <= RD_CMD;
              idx      <= idx + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  p_mosi_while_low_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ee_mosi) |-> !ee_sck);

  p_select_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> (!ee_sck && !ee_mosi));

  p_valid_at_deselect_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (!ee_cs && $past(ee_cs)));

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !ee_cs));

  p_zero_count_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && word_count == '0) |=> (done && !ee_cs && !ee_sck));

  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> $stable(last_idx));
endmodule

// File: tb/mw_burst_rd_bench.sv
module mw_burst_rd_bench;
  localparam int DIV = 2;
  localparam int AW  = 6;
  localparam int CW  = AW + 1;
  localparam int LO  = DIV;
  localparam int HI  = 3 * DIV;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] word_count = '0;
  logic busy, rd_valid, done, ee_cs, ee_sck, ee_mosi;
  logic ee_miso = 1'b0;
  logic [15:0] rd_data;
  logic [CW-1:0] rd_idx;

  always #4 clk = ~clk;

  mw_burst_rd #(.WIDE_ADDR(1'b0), .DIV(DIV)) u_mw_burst_rd (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .word_count(word_count), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_idx(rd_idx), .done(done), .ee_cs(ee_cs),
    .ee_sck(ee_sck), .ee_mosi(ee_mosi), .ee_miso(ee_miso)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] mem [64];
  int exp_q[$];
  int exp_idx = 0;
  bit expect_done = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // device model and protocol observer
  bit prev_sck = 0, prev_cs = 0, prev_mosi = 0;
  int m_ph = 0, m_n = 0, m_zeros = 0, m_op = 0, m_a = 0;
  int hi_len = 0, lo_len = 0, gap_rises = 0;
  bit in_gap = 0;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      automatic bit rise = ee_sck && !prev_sck;
      automatic bit fall = !ee_sck && prev_sck;
      if (ee_mosi != prev_mosi) chk(!ee_sck, "R7", "mosi moved with sck high", ee_sck, 0);
      chk(!ee_cs || busy, "R10", "select without busy", busy, 1);
      if (fall) begin
        chk(hi_len == HI, "R6", "high phase length", hi_len, HI);
        hi_len = 0;
        lo_len = 0;
      end
      if (!busy) lo_len = 0;
      else if (!ee_sck) lo_len++;
      if (ee_sck) hi_len++;
      if (rise) begin
        chk(lo_len == LO, "R6", "low phase length", lo_len, LO);
        lo_len = 0;
      end
      if (ee_cs && !prev_cs) begin
        if (in_gap) chk(gap_rises == 1, "R5", "clocks between frames", gap_rises, 1);
        in_gap = 0;
        m_ph = 0; m_n = 0; m_zeros = 0; m_op = 0; m_a = 0;
      end
      if (!ee_cs && prev_cs) begin
        chk(m_ph == 3 && m_n == 17, "R3", "read clocks in frame", m_n, 17);
        in_gap = 1;
        gap_rises = 0;
      end
      if (!ee_cs && rise && in_gap) gap_rises++;
      if (ee_cs && rise) begin
        case (m_ph)
          0: if (ee_mosi) begin
               chk(m_zeros == 1, "R2", "zeros before start bit", m_zeros, 1);
               m_ph = 1; m_n = 0;
             end else m_zeros++;
          1: begin
               m_op = (m_op << 1) | int'(ee_mosi);
               m_n++;
               if (m_n == 2) begin
                 chk(m_op == 2, "R2", "opcode", m_op, 2);
                 m_ph = 2; m_n = 0;
               end
             end
          2: begin
               m_a = ((m_a << 1) | int'(ee_mosi)) & 63;
               m_n++;
               if (m_n == AW) begin
                 chk(exp_q.size() > 0 && m_a == exp_q[0], "R4", "frame address", m_a,
                     exp_q.size() > 0 ? exp_q[0] : -1);
                 m_ph = 3; m_n = 0;
               end
             end
          default: begin
               if (m_n == 0 || m_n > 16) ee_miso <= 1'b0;
               else ee_miso <= mem[m_a][16-m_n];
               m_n++;
             end
        endcase
      end
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(0, "R8", "unexpected word", rd_idx, -1);
        else begin
          automatic int a = exp_q.pop_front();
          chk(rd_data == mem[a], "R3", "word data", rd_data, mem[a]);
          chk(rd_idx == CW'(exp_idx), "R4", "word index", rd_idx, exp_idx);
          exp_idx++;
        end
      end
      if (done) begin
        chk(expect_done, "R5", "unexpected done", 1, 0);
        chk(exp_q.size() == 0, "R5", "words left at done", exp_q.size(), 0);
        chk(!busy, "R10", "busy at done", busy, 0);
        if (in_gap) chk(gap_rises == 1, "R5", "clocks after last frame", gap_rises, 1);
        in_gap = 0;
        expect_done = 0;
      end
      prev_sck = ee_sck; prev_cs = ee_cs; prev_mosi = ee_mosi;
    end
  end

  task automatic burst(int sa, int cnt, bit poke);
    @(negedge clk);
    for (int k = 0; k < cnt; k++) exp_q.push_back((sa + k) % 64);
    exp_idx = 0;
    expect_done = 1;
    start_addr = AW'(sa);
    word_count = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (cnt == 0) begin
      chk(done, "R9", "done after empty request", done, 1);
      chk(!ee_cs && !busy, "R9", "bus quiet on empty request", ee_cs, 0);
    end else begin
      chk(busy, "R10", "busy after start", busy, 1);
    end
    if (poke) begin
      repeat (40) @(negedge clk);
      start_addr = AW'(30);
      word_count = CW'(5);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (expect_done) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h2F1D) ^ 16'hC35A;
    repeat (4) @(negedge clk);
    chk(!ee_cs && !ee_sck && !ee_mosi, "R1", "bus idle in reset", {ee_cs, ee_sck, ee_mosi}, 0);
    chk(!busy && !rd_valid && !done, "R1", "status idle in reset", {busy, rd_valid, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!ee_cs && !busy && !done, "R1", "idle after reset", {ee_cs, busy, done}, 0);
    burst(5, 3, 0);
    burst(62, 4, 0);
    burst(0, 1, 0);
    burst(0, 0, 0);
    burst(10, 2, 1);
    repeat (300) @(negedge clk);
    chk(!busy && !ee_cs, "R8", "no run from ignored start", {busy, ee_cs}, 0);
    burst(63, 2, 0);
    burst(33, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule